// File: doc/BRIEF.md
# Key-Protected Independent Watchdog Timer

This block is a watchdog timer that counts on its own slow tick enable and pulses a system reset request if software stops refreshing it. Software never writes control bits directly. It writes command codes to a key register: one code starts the timer, one refreshes the count, and one opens the timing registers for a single change. Two timing registers set the countdown. A 3-bit divider code picks the slow-clock division, and an 8-bit refill value is copied into the counter on every refresh.

The tick input is one clock-wide enable taken from the low-speed oscillator. Counting runs at half that rate, and the selected divider is then applied to it. A strap input can make the timer run straight out of reset with no key write. Once the timer is running, no key stops it. After it expires it emits one reset pulse and then waits, frozen, for the system reset.

The control state machine has four states. IDLE is stopped after reset, with the counter at 0xFF. RUN is counting. FIRE lasts one cycle and drives the reset pulse. HALT is expired and frozen. Its transitions are:
- IDLE→RUN, on a start key or on the strap.
- RUN→RUN, on a tick step or a refresh.
- RUN→FIRE, when the count reaches zero.
- FIRE→HALT, always.
- HALT→HALT, always.

A separate two-state lock machine, SHUT and OPEN, guards the timing registers.

Top module: `kwdt_top`

## Requirements
- R1: After rst_n is asserted, the timer state is as follows: stopped (unless hw_start is high), registers locked, divider code 0, refill value 0xFF, and wdt_rst low.
- R2: While stopped, the timer gives no reset pulse, whatever tick_en does.
- R3: A write of 0xCC to address 0 (the key register) starts the timer. The counter is set to 0xFF and the prescaler phase is cleared.
- R4: While running, the counter drops by one after every (8 << code) tick_en pulses. wdt_rst is high in the cycle after the edge at which the counter reaches 0. With code 0 and a tick every cycle, this cycle is 2040 cycles after the start edge.
- R5: While running, a write of 0xAA to the key register copies the refill value into the counter. A refresh wins over a decrement at the same edge. A refill value of 0 fires at once.
- R6: Address 1 bits [2:0] hold the divider code. Codes 0 to 6 divide the half-rate tick by 4, 8, 16, 32, 64, 128 and 256. Code 7 behaves like code 6.
- R7: A write of 0x55 to the key register opens the lock, and any other key value closes it. Writes to address 1 or to address 2 (the 8-bit refill value) while the lock is closed are ignored.
- R8: With hw_start high, the timer runs from the first edge after reset without any key write.
- R9: Once running, no key value stops the timer. After it fires, it gives no further pulse and ignores all keys until rst_n.
- R10: wdt_rst is high for exactly one clock cycle per expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous block reset |
| tick_en | input | 1 | One-cycle enable per low-speed oscillator period |
| hw_start | input | 1 | Strap: run from reset without a key |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 key, 1 divider code, 2 refill value |
| bus_wdata | input | 8 | Write data |
| wdt_rst | output | 1 | One-cycle system reset request |

## Verification
The only observable port is wdt_rst. Any wrong internal state therefore shows up as a reset pulse that comes early, comes late, is missing, or is repeated. For example, a prescaler limit that is off by one shifts the pulse by one tick for every count step. A lock that leaks lets a refill value of 0 or 2 through, which fires within a few cycles. A missed refresh fires as soon as the untouched count runs out. The bench runs a reference model in step with the design and compares wdt_rst on every cycle, so the first cycle in which the two differ is reported. Start-to-pulse distances are also checked exactly for several divider codes.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

    localparam logic [7:0] KEY_START = 8'hCC;
    localparam logic [7:0] KEY_FEED  = 8'hAA;
    localparam logic [7:0] KEY_OPEN  = 8'h55;

    localparam logic [1:0] ADDR_KEY    = 2'd0;
    localparam logic [1:0] ADDR_DIV    = 2'd1;
    localparam logic [1:0] ADDR_REFILL = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIRE = 2'd2,
        ST_HALT = 2'd3
    } wd_state_e;

    typedef enum logic {
        LK_SHUT = 1'b0,
        LK_OPEN = 1'b1
    } lock_state_e;

endpackage

// File: rtl/kwdt_regs.sv
module kwdt_regs
    import kwdt_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 8,
    parameter int PRE_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              key_start,
    output logic              key_feed,
    output logic [PRE_W-1:0]  div_code,
    output logic [CNT_W-1:0]  refill_val,
    output logic              unlocked
);

    lock_state_e lock_q, lock_d;
    logic        key_wr;
    logic        div_wr;
    logic        refill_wr;

    always_comb begin
        key_wr    = bus_we && (bus_addr == ADDR_KEY);
        key_start = key_wr && (bus_wdata == KEY_START);
        key_feed  = key_wr && (bus_wdata == KEY_FEED);
        div_wr    = bus_we && (bus_addr == ADDR_DIV)    && (lock_q == LK_OPEN);
        refill_wr = bus_we && (bus_addr == ADDR_REFILL) && (lock_q == LK_OPEN);
    end

    // lock machine: any key write decides the next lock state
    always_comb begin
        lock_d = lock_q;
        unique case (lock_q)
            LK_SHUT: if (key_wr && (bus_wdata == KEY_OPEN)) lock_d = LK_OPEN;
            LK_OPEN: if (key_wr && (bus_wdata != KEY_OPEN)) lock_d = LK_SHUT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lock_q <= LK_SHUT;
        else        lock_q <= lock_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_code   <= '0;
            refill_val <= '1;
        end else begin
            if (div_wr)    div_code   <= bus_wdata[PRE_W-1:0];
            if (refill_wr) refill_val <= bus_wdata[CNT_W-1:0];
        end
    end

    always_comb unlocked = (lock_q == LK_OPEN);

endmodule

// File: rtl/kwdt_prescale.sv
module kwdt_prescale #(
    parameter int PRE_W      = 3,
    parameter int MAX_CODE   = 6,
    parameter int BASE_SHIFT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clear,
    input  logic             tick_en,
    input  logic [PRE_W-1:0] div_code,
    output logic             step
);

    localparam int PC_W = BASE_SHIFT + MAX_CODE;

    logic [PC_W-1:0]  pre_q;
    logic [PC_W-1:0]  limit;
    logic [PRE_W-1:0] code_eff;

    // half-rate stage and selected divider folded into one terminal count
    always_comb begin
        code_eff = (div_code > PRE_W'(MAX_CODE)) ? PRE_W'(MAX_CODE) : div_code;
        limit    = PC_W'((32'd1 << (BASE_SHIFT + int'(code_eff))) - 32'd1);
        step     = run && tick_en && (pre_q >= limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              pre_q <= '0;
        else if (clear)          pre_q <= '0;
        else if (run && tick_en) pre_q <= step ? '0 : pre_q + 1'b1;
    end

endmodule

// File: rtl/kwdt_fsm.sv
module kwdt_fsm
    import kwdt_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hw_start,
    input  logic             key_start,
    input  logic             key_feed,
    input  logic             step,
    input  logic [CNT_W-1:0] refill_val,
    output wd_state_e        state,
    output logic [CNT_W-1:0] count,
    output logic             run,
    output logic             start_evt,
    output logic             wdt_rst
);

    wd_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d   = state_q;
        cnt_d     = cnt_q;
        start_evt = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (hw_start || key_start) begin
                    state_d   = ST_RUN;
                    cnt_d     = '1;
                    start_evt = 1'b1;
                end
            end
            ST_RUN: begin
                if (key_feed) begin
                    cnt_d = refill_val;
                    if (refill_val == '0) state_d = ST_FIRE;
                end else if (step) begin
                    cnt_d = cnt_q - 1'b1;
                    if (cnt_q == CNT_W'(1)) state_d = ST_FIRE;
                end
            end
            ST_FIRE: state_d = ST_HALT;
            ST_HALT: state_d = ST_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '1;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state   = state_q;
        count   = cnt_q;
        run     = (state_q == ST_RUN);
        wdt_rst = (state_q == ST_FIRE);
    end

endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
    import kwdt_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int CNT_W      = 8,
    parameter int PRE_W      = 3,
    parameter int MAX_CODE   = 6,
    parameter int BASE_SHIFT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              hw_start,
    input  logic              bus_we,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              wdt_rst
);

    logic             key_start;
    logic             key_feed;
    logic [PRE_W-1:0] div_code;
    logic [CNT_W-1:0] refill_val;
    logic             unlocked;
    logic             step;
    logic             run;
    logic             start_evt;
    logic [CNT_W-1:0] count;
    wd_state_e        state;

    kwdt_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .PRE_W(PRE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .key_start(key_start), .key_feed(key_feed),
        .div_code(div_code), .refill_val(refill_val), .unlocked(unlocked)
    );

    kwdt_prescale #(.PRE_W(PRE_W), .MAX_CODE(MAX_CODE), .BASE_SHIFT(BASE_SHIFT)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(run), .clear(start_evt),
        .tick_en(tick_en), .div_code(div_code), .step(step)
    );

    kwdt_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .hw_start(hw_start), .key_start(key_start),
        .key_feed(key_feed), .step(step), .refill_val(refill_val),
        .state(state), .count(count), .run(run), .start_evt(start_evt),
        .wdt_rst(wdt_rst)
    );

endmodule

// File: rtl/kwdt_checker.sv
module kwdt_checker
    import kwdt_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int PRE_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hw_start,
    input logic             bus_we,
    input logic [1:0]       bus_addr,
    input logic             wdt_rst,
    input wd_state_e        state,
    input logic [CNT_W-1:0] count,
    input logic             step,
    input logic             key_start,
    input logic             key_feed,
    input logic             unlocked,
    input logic [PRE_W-1:0] div_code,
    input logic [CNT_W-1:0] refill_val
);

    assert_pulse_width_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst |=> !wdt_rst);

    assert_fire_at_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst |-> (count == '0));

    assert_decrement_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && step && !key_feed && count > CNT_W'(1))
        |=> (count == $past(count) - 1'b1));

    assert_feed_loads_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && key_feed) |=> (count == $past(refill_val)));

    assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !hw_start && !key_start) |=> (state == ST_IDLE && !wdt_rst));

    assert_lock_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!unlocked && bus_we && bus_addr != 2'd0)
        |=> ($stable(refill_val) && $stable(div_code)));

    assert_no_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> (state != ST_IDLE));

endmodule

bind kwdt_top kwdt_checker u_chk (
    .clk(clk), .rst_n(rst_n), .hw_start(hw_start), .bus_we(bus_we),
    .bus_addr(bus_addr), .wdt_rst(wdt_rst), .state(state), .count(count),
    .step(step), .key_start(key_start), .key_feed(key_feed),
    .unlocked(unlocked), .div_code(div_code), .refill_val(refill_val)
);

// File: tb/kwdt_top_bench.sv
`timescale 1ns/1ps
module kwdt_top_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       hw_start = 1'b0;
    logic       bus_we = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic       wdt_rst;

    int checks = 0;
    int errors = 0;
    int pulse_cnt = 0;
    int tick_per = 1;
    int tphase = 0;
    string cur_req = "R1";

    // reference model state
    int m_mode, m_cnt, m_pre, m_div, m_rld, m_lim;
    bit m_unl, m_stp, m_wkey;
    bit m_rst;

    always #2.5 clk = ~clk;

    kwdt_top u_kwdt_top (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .hw_start(hw_start),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .wdt_rst(wdt_rst)
    );

    always @(negedge clk) begin
        tick_en <= (tick_per > 0) && ((tphase % ((tick_per > 0) ? tick_per : 1)) == 0);
        tphase  <= tphase + 1;
    end

    // behavioural model: mode 0 stopped, 1 running, 2 firing, 3 expired
    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_cnt = 255; m_pre = 0; m_div = 0; m_rld = 255; m_unl = 0;
        end else begin
            m_wkey = bus_we && (bus_addr == 2'd0);
            m_lim  = (8 << ((m_div > 6) ? 6 : m_div)) - 1;
            case (m_mode)
                0: if (hw_start || (m_wkey && bus_wdata == 8'hCC)) begin
                       m_mode = 1; m_cnt = 255; m_pre = 0;
                   end
                1: begin
                       m_stp = tick_en && (m_pre >= m_lim);
                       if (tick_en) m_pre = m_stp ? 0 : m_pre + 1;
                       if (m_wkey && bus_wdata == 8'hAA) begin
                           m_cnt = m_rld;
                           if (m_rld == 0) m_mode = 2;
                       end else if (m_stp) begin
                           m_cnt = m_cnt - 1;
                           if (m_cnt == 0) m_mode = 2;
                       end
                   end
                2: m_mode = 3;
                default: ;
            endcase
            if (bus_we && m_unl && bus_addr == 2'd1) m_div = int'(bus_wdata) & 7;
            if (bus_we && m_unl && bus_addr == 2'd2) m_rld = int'(bus_wdata);
            if (m_wkey) m_unl = (bus_wdata == 8'h55);
        end
        m_rst = (m_mode == 2);
    end

    always @(negedge clk) begin
        checks++;
        if (wdt_rst !== m_rst) begin
            errors++;
            $display("FAIL %s cycle compare t=%0t wdt_rst act=%b exp=%b", cur_req, $time, wdt_rst, m_rst);
        end
        if (wdt_rst === 1'b1) pulse_cnt++;
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = 2'd0; bus_wdata = 8'd0;
    endtask

    task automatic do_reset(input logic hw);
        hw_start = hw;
        rst_n = 1'b0;
        cyc(3);
        pulse_cnt = 0;
        rst_n = 1'b1;
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic wait_pulse(input int limit, output int k);
        k = 0;
        while (wdt_rst !== 1'b1 && k < limit) begin
            @(negedge clk);
            k++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog timeout in %s", cur_req);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int k;
        cyc(2);
        cur_req = "R1";
        check("R1 wdt_rst low in reset", int'(wdt_rst), 0);
        do_reset(1'b0);

        cur_req = "R2";
        tick_per = 1;
        cyc(300);
        check("R2 no pulse while stopped", pulse_cnt, 0);

        cur_req = "R4";
        wr(2'd0, 8'hCC);
        wait_pulse(3000, k);
        check("R4 start-to-pulse distance code 0", k, 2040);
        cur_req = "R9";
        wr(2'd0, 8'hAA); wr(2'd0, 8'hCC); wr(2'd0, 8'h55);
        cyc(3000);
        check("R9 single pulse after expiry", pulse_cnt, 1);
        check("R10 pulse count one", pulse_cnt, 1);

        cur_req = "R5";
        do_reset(1'b0);
        wr(2'd0, 8'hCC);
        wr(2'd2, 8'h02);
        for (int i = 0; i < 4; i++) begin
            cyc(1500);
            wr(2'd0, 8'hAA);
            wr(2'd0, 8'h00);
        end
        check("R5 refresh keeps timer quiet; R7 locked refill ignored", pulse_cnt, 0);
        cyc(2100);
        check("R9 running timer still fires after stray keys", pulse_cnt, 1);

        cur_req = "R6";
        do_reset(1'b0);
        wr(2'd0, 8'h55); wr(2'd1, 8'h06);
        wr(2'd0, 8'h55); wr(2'd2, 8'h03);
        wr(2'd0, 8'hCC); wr(2'd0, 8'hAA);
        wait_pulse(3000, k);
        check("R6 divider code 6 distance", k, 1535);

        do_reset(1'b0);
        wr(2'd0, 8'h55); wr(2'd1, 8'h07);
        wr(2'd0, 8'h55); wr(2'd2, 8'h03);
        wr(2'd0, 8'hCC); wr(2'd0, 8'hAA);
        wait_pulse(3000, k);
        check("R6 divider code 7 same as 6", k, 1535);

        cur_req = "R8";
        tick_per = 2;
        do_reset(1'b1);
        cyc(4300);
        check("R8 strap start fires without key", pulse_cnt, 1);
        tick_per = 1;

        cur_req = "R5";
        do_reset(1'b0);
        wr(2'd0, 8'h55); wr(2'd2, 8'h00);
        wr(2'd0, 8'hCC); wr(2'd0, 8'hAA);
        wait_pulse(10, k);
        check("R5 zero refill fires at once", k, 0);

        cur_req = "R7";
        do_reset(1'b0);
        wr(2'd0, 8'h55); wr(2'd0, 8'h12);
        wr(2'd2, 8'h00);
        wr(2'd0, 8'hCC); wr(2'd0, 8'hAA);
        cyc(500);
        check("R7 relock blocks refill write", pulse_cnt, 0);

        cur_req = "R3";
        tick_per = 3;
        do_reset(1'b0);
        cyc(50);
        wr(2'd0, 8'hCC);
        cyc(6200);
        check("R3 start key leads to one expiry", pulse_cnt, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule